// File: doc/BRIEF.md
# Pipelined Dual-Mode CORDIC Engine

This block is a fully pipelined shift-and-add CORDIC unit. It accepts one sample per clock. Each sample has an x/y vector and an angle, plus a flag that selects the operation for that sample alone. In rotation mode the vector is turned by the input angle, and the stages work the residual angle toward zero. In vectoring mode the stages work the y component toward zero. The angle output then holds the input angle plus the vector's phase, and the x output holds the vector's length.

The mode flag and a valid flag travel down the pipeline beside the data. One instance can therefore be time-shared, for example between a polar-to-rectangular conversion and a phase detector in a feedback loop, with samples of either kind entering on consecutive cycles and no flush between them. Both output coordinates carry the uncompensated CORDIC gain of about 1.64676. Any scaling correction belongs to the user of the block.

Angles use a two's-complement binary code in which the full word spans one turn. A first pipeline stage turns the vector by a quarter turn where needed, so every input in the plane converges.

Top module: `cordic_engine`

## Requirements
- R1: A sample presented with `inValid` high appears on the outputs with `outValid` high exactly STAGES+1 clock edges later (17 by default). A new sample is accepted on every cycle, and every accepted sample produces exactly one output.
- R2: `outVectoring` equals the `inVectoring` value of the same sample. Rotation and vectoring samples may alternate on consecutive cycles, and each sample is processed in its own mode.
- R3: In rotation mode (`inVectoring`=0), with |angle| of at most a quarter turn, (`outX`,`outY`) equals 1.64676·(x·cosθ − y·sinθ, x·sinθ + y·cosθ) within 32 LSB.
- R4: In rotation mode, `outZ` (the residual angle) stays within ±(STAGES+4) LSB of zero.
- R5: In vectoring mode (`inVectoring`=1), `outZ` equals `inZ` + atan2(y, x), wrapped to the angle word, within 12 LSB, for vectors of length at least 50000 LSB.
- R6: In vectoring mode, `outX` equals 1.64676·sqrt(x²+y²) within 32 LSB, and `outY` stays within 32 LSB of zero.
- R7: Vectoring is correct for inputs with x<0 in both half planes. An input on the negative x axis yields an angle of a half turn (code 0x20000 for an 18-bit angle).
- R8: Rotation is correct for angles beyond ±a quarter turn, including the most negative code (−a half turn), meeting the same tolerance as R3.
- R9: While `rst` is high, `inValid` is ignored. When `rst` is asserted while samples are in flight, those samples are discarded and `outValid` stays low until new samples are issued.
- R10: The angle code maps 2^AW LSB to one full turn in two's complement, so a quarter turn is 2^(AW−2) (65536 for AW=18). Vectoring (0, +y) yields that code within 12 LSB.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high, clears the valid pipeline |
| inValid | input | 1 | Sample present on the inputs this cycle |
| inVectoring | input | 1 | 1 selects vectoring, 0 selects rotation, for this sample |
| inX | input | CW (18) | Input x coordinate, signed |
| inY | input | CW (18) | Input y coordinate, signed |
| inZ | input | AW (18) | Input angle, two's complement, full word equals one turn |
| outValid | output | 1 | Result present on the outputs |
| outVectoring | output | 1 | Mode the result was computed in |
| outX | output | CW+GUARD (20) | Output x coordinate, signed, includes CORDIC gain |
| outY | output | CW+GUARD (20) | Output y coordinate, signed, includes CORDIC gain |
| outZ | output | AW (18) | Output angle (vectoring) or residual angle (rotation) |

## Verification
The bench streams samples of both modes back to back through the pipeline, with one bubble. A design that read the mode from the wrong pipeline stage would process neighbouring samples in each other's mode, and the mode, coordinate and angle checks would report it.

The corner cases are:
- vectors in the left half plane and on the negative x axis, where a missing or mis-signed pre-rotation gives an angle off by a quarter or half turn;
- rotation angles past a quarter turn and exactly minus a half turn, where the stages alone cannot converge;
- the exact quarter-turn code.

A reset is also asserted while samples are in flight: a pipeline that kept stale valid flags would emit phantom results after the reset. A wrong entry in the arctangent table, or a wrong shift, shows up as an angle or magnitude error beyond tolerance.

// File: rtl/cordic_pkg.sv
package cordic_pkg;

  // Per-sample control strobe that travels beside the data.
  typedef struct packed {
    logic valid;
    logic vectoring;
  } tag_t;

  // arctan(2^-i) scaled so that 2^32 equals one turn.
  function automatic logic [31:0] atanTurn32(input int idx);
    logic [31:0] v;
    case (idx)
      0:  v = 32'h20000000;
      1:  v = 32'h12E4051E;
      2:  v = 32'h09FB385B;
      3:  v = 32'h051111D4;
      4:  v = 32'h028B0D43;
      5:  v = 32'h0145D7E1;
      6:  v = 32'h00A2F61E;
      7:  v = 32'h00517C55;
      8:  v = 32'h0028BE53;
      9:  v = 32'h00145F2F;
      10: v = 32'h000A2F98;
      11: v = 32'h000517CC;
      12: v = 32'h00028BE6;
      13: v = 32'h000145F3;
      14: v = 32'h0000A2FA;
      15: v = 32'h0000517D;
      16: v = 32'h000028BE;
      17: v = 32'h0000145F;
      18: v = 32'h00000A30;
      19: v = 32'h00000518;
      20: v = 32'h0000028C;
      21: v = 32'h00000146;
      22: v = 32'h000000A3;
      23: v = 32'h00000051;
      24: v = 32'h00000029;
      25: v = 32'h00000014;
      26: v = 32'h0000000A;
      27: v = 32'h00000005;
      28: v = 32'h00000003;
      29: v = 32'h00000001;
      30: v = 32'h00000001;
      default: v = 32'h00000000;
    endcase
    return v;
  endfunction

  // Same constant rounded to an angle word of aw bits (aw <= 31).
  function automatic logic [31:0] atanTurnScaled(input int idx, input int aw);
    logic [32:0] sum;
    sum = {1'b0, atanTurn32(idx)} + (33'd1 << (31 - aw));
    sum = sum >> (32 - aw);
    return sum[31:0];
  endfunction

endpackage

// File: rtl/cordic_ctrl.sv
module cordic_ctrl
  import cordic_pkg::*;
#(
  parameter int STAGES = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  tag_t              inTag,
  output tag_t [STAGES:0]   tagPipe
);

  // Tag shift register: level k describes the sample held in data level k.
  always_ff @(posedge clk) begin
    if (rst) begin
      tagPipe <= '0;
    end else begin
      tagPipe[0] <= inTag;
      for (int k = 1; k <= STAGES; k++) begin
        tagPipe[k] <= tagPipe[k-1];
      end
    end
  end

endmodule

// File: rtl/cordic_stage.sv
module cordic_stage
  import cordic_pkg::*;
#(
  parameter int                   IW    = 20,
  parameter int                   AW    = 18,
  parameter int                   SHIFT = 0,
  parameter logic signed [AW-1:0] STEP  = '0
) (
  input  logic                 clk,
  input  tag_t                 stb,
  input  logic signed [IW-1:0] xIn,
  input  logic signed [IW-1:0] yIn,
  input  logic signed [AW-1:0] zIn,
  output logic signed [IW-1:0] xOut,
  output logic signed [IW-1:0] yOut,
  output logic signed [AW-1:0] zOut
);

  logic signed [IW-1:0] xSh;
  logic signed [IW-1:0] ySh;
  logic                 turnCcw;

  always_comb begin
    xSh = xIn >>> SHIFT;
    ySh = yIn >>> SHIFT;
    // Vectoring: turn toward y = 0. Rotation: turn toward residual = 0.
    turnCcw = stb.vectoring ? yIn[IW-1] : ~zIn[AW-1];
  end

  always_ff @(posedge clk) begin
    if (stb.valid) begin
      if (turnCcw) begin
        xOut <= xIn - ySh;
        yOut <= yIn + xSh;
        zOut <= zIn - STEP;
      end else begin
        xOut <= xIn + ySh;
        yOut <= yIn - xSh;
        zOut <= zIn + STEP;
      end
    end
  end

endmodule

// File: rtl/cordic_datapath.sv
module cordic_datapath
  import cordic_pkg::*;
#(
  parameter int STAGES = 16,
  parameter int CW     = 18,
  parameter int GUARD  = 2,
  parameter int AW     = 18
) (
  input  logic                        clk,
  input  logic                        rst,
  input  tag_t                        inTag,
  input  tag_t [STAGES:0]             tagPipe,
  input  logic signed [CW-1:0]        inX,
  input  logic signed [CW-1:0]        inY,
  input  logic signed [AW-1:0]        inZ,
  output logic signed [CW+GUARD-1:0]  outX,
  output logic signed [CW+GUARD-1:0]  outY,
  output logic signed [AW-1:0]        outZ
);

  localparam int IW = CW + GUARD;
  localparam int QUARTER_I = 1 << (AW - 2);
  localparam logic signed [AW-1:0] QUARTER = AW'(QUARTER_I);
  localparam logic signed [AW-1:0] RES_TOL = AW'(STAGES + 4);
  localparam int YTOL_I = ((1 << IW) >> (STAGES - 1)) + STAGES + 4;
  localparam logic signed [IW-1:0] Y_TOL = IW'(YTOL_I);

  logic signed [IW-1:0] xs [0:STAGES];
  logic signed [IW-1:0] ys [0:STAGES];
  logic signed [AW-1:0] zs [0:STAGES];

  logic signed [IW-1:0] extX;
  logic signed [IW-1:0] extY;
  logic signed [IW-1:0] preX;
  logic signed [IW-1:0] preY;
  logic signed [AW-1:0] preZ;

  // Quadrant pre-rotation by a quarter turn into the convergence range.
  always_comb begin
    extX = {{GUARD{inX[CW-1]}}, inX};
    extY = {{GUARD{inY[CW-1]}}, inY};
    preX = extX;
    preY = extY;
    preZ = inZ;
    if (inTag.vectoring) begin
      if (extX < 0) begin
        if (extY >= 0) begin
          preX = extY;
          preY = -extX;
          preZ = inZ + QUARTER;
        end else begin
          preX = -extY;
          preY = extX;
          preZ = inZ - QUARTER;
        end
      end
    end else begin
      if (inZ > QUARTER) begin
        preX = -extY;
        preY = extX;
        preZ = inZ - QUARTER;
      end else if (inZ < -QUARTER) begin
        preX = extY;
        preY = -extX;
        preZ = inZ + QUARTER;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (inTag.valid) begin
      xs[0] <= preX;
      ys[0] <= preY;
      zs[0] <= preZ;
    end
  end

  for (genvar k = 0; k < STAGES; k++) begin : gStage
    cordic_stage #(
      .IW    (IW),
      .AW    (AW),
      .SHIFT (k),
      .STEP  (AW'(atanTurnScaled(k, AW)))
    ) uStage (
      .clk  (clk),
      .stb  (tagPipe[k]),
      .xIn  (xs[k]),
      .yIn  (ys[k]),
      .zIn  (zs[k]),
      .xOut (xs[k+1]),
      .yOut (ys[k+1]),
      .zOut (zs[k+1])
    );
  end

  assign outX = xs[STAGES];
  assign outY = ys[STAGES];
  assign outZ = zs[STAGES];

  AST_PREROT_ANGLE_RANGE: assert property (@(posedge clk) disable iff (rst)
    (tagPipe[0].valid && !tagPipe[0].vectoring) |-> (zs[0] <= QUARTER && zs[0] >= -QUARTER)); // R8

  AST_PREROT_X_NONNEG: assert property (@(posedge clk) disable iff (rst)
    (tagPipe[0].valid && tagPipe[0].vectoring) |-> (xs[0] >= 0)); // R7

  AST_ROT_RESIDUAL_SMALL: assert property (@(posedge clk) disable iff (rst)
    (tagPipe[STAGES].valid && !tagPipe[STAGES].vectoring) |-> (outZ <= RES_TOL && outZ >= -RES_TOL)); // R4

  AST_VEC_Y_NULLED: assert property (@(posedge clk) disable iff (rst)
    (tagPipe[STAGES].valid && tagPipe[STAGES].vectoring) |-> (outY <= Y_TOL && outY >= -Y_TOL)); // R6

  AST_VEC_MAG_NONNEG: assert property (@(posedge clk) disable iff (rst)
    (tagPipe[STAGES].valid && tagPipe[STAGES].vectoring) |-> (outX >= 0)); // R6

endmodule

// File: rtl/cordic_engine.sv
module cordic_engine
  import cordic_pkg::*;
#(
  parameter int STAGES = 16,
  parameter int CW     = 18,
  parameter int GUARD  = 2,
  parameter int AW     = 18
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        inValid,
  input  logic                        inVectoring,
  input  logic signed [CW-1:0]        inX,
  input  logic signed [CW-1:0]        inY,
  input  logic signed [AW-1:0]        inZ,
  output logic                        outValid,
  output logic                        outVectoring,
  output logic signed [CW+GUARD-1:0]  outX,
  output logic signed [CW+GUARD-1:0]  outY,
  output logic signed [AW-1:0]        outZ
);

  localparam int CNT_W = $clog2(STAGES + 3);

  tag_t            inTag;
  tag_t [STAGES:0] tagPipe;

  assign inTag.valid     = inValid;
  assign inTag.vectoring = inVectoring;

  cordic_ctrl #(
    .STAGES (STAGES)
  ) uCtrl (
    .clk     (clk),
    .rst     (rst),
    .inTag   (inTag),
    .tagPipe (tagPipe)
  );

  cordic_datapath #(
    .STAGES (STAGES),
    .CW     (CW),
    .GUARD  (GUARD),
    .AW     (AW)
  ) uData (
    .clk     (clk),
    .rst     (rst),
    .inTag   (inTag),
    .tagPipe (tagPipe),
    .inX     (inX),
    .inY     (inY),
    .inZ     (inZ),
    .outX    (outX),
    .outY    (outY),
    .outZ    (outZ)
  );

  assign outValid     = tagPipe[STAGES].valid;
  assign outVectoring = tagPipe[STAGES].vectoring;

  // Occupancy counter: accepted samples not yet emitted.
  logic [CNT_W-1:0] inFlight;

  always_ff @(posedge clk) begin
    if (rst) begin
      inFlight <= '0;
    end else begin
      inFlight <= inFlight + CNT_W'(inValid) - CNT_W'(outValid);
    end
  end

  AST_INFLIGHT_BOUND: assert property (@(posedge clk) disable iff (rst)
    inFlight <= CNT_W'(STAGES + 1)); // R1

  AST_NO_PHANTOM_OUTPUT: assert property (@(posedge clk) disable iff (rst)
    outValid |-> (inFlight != '0)); // R9

endmodule

// File: tb/cordic_engine_test.sv
module cordic_engine_test;

  localparam int STAGES = 16;
  localparam int CW     = 18;
  localparam int GUARD  = 2;
  localparam int AW     = 18;
  localparam int QTURN  = 1 << (AW - 2);
  localparam real PI    = 3.14159265358979;
  localparam int NVEC   = 15;
  localparam int COORD_TOL = 32;
  localparam int VANG_TOL  = 12;
  localparam int RES_TOL   = STAGES + 4;

  // {valid, vectoring, x[17:0], y[17:0], z[17:0]}
  localparam logic [55:0] TBL [NVEC] = '{
    {1'b1, 1'b0,  18'sd100000,  18'sd0,       18'sd32768},
    {1'b1, 1'b0,  18'sd50000,  -18'sd70000,  -18'sd21845},
    {1'b1, 1'b0, -18'sd90000,   18'sd40000,   18'sd100000},
    {1'b1, 1'b0,  18'sd80000,   18'sd80000,  -18'sd120000},
    {1'b0, 1'b0,  18'sd0,       18'sd0,       18'sd0},
    {1'b1, 1'b1,  18'sd100000,  18'sd50000,   18'sd0},
    {1'b1, 1'b1, -18'sd80000,   18'sd60000,   18'sd0},
    {1'b1, 1'b1, -18'sd70000,  -18'sd90000,   18'sd1000},
    {1'b1, 1'b0,  18'sd120000, -18'sd30000,   18'sd65536},
    {1'b1, 1'b1,  18'sd60000,  -18'sd110000, -18'sd50000},
    {1'b1, 1'b1,  18'sd130000,  18'sd130000,  18'sd0},
    {1'b1, 1'b0, -18'sd131072, -18'sd131072, -18'sd131072},
    {1'b1, 1'b1, -18'sd131072,  18'sd0,       18'sd0},
    {1'b1, 1'b1,  18'sd0,      -18'sd100000,  18'sd0},
    {1'b1, 1'b0,  18'sd0,       18'sd0,       18'sd5000}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic inValid = 1'b0;
  logic inVectoring = 1'b0;
  logic signed [CW-1:0] inX = '0;
  logic signed [CW-1:0] inY = '0;
  logic signed [AW-1:0] inZ = '0;
  logic outValid;
  logic outVectoring;
  logic signed [CW+GUARD-1:0] outX;
  logic signed [CW+GUARD-1:0] outY;
  logic signed [AW-1:0] outZ;

  cordic_engine #(
    .STAGES (STAGES), .CW (CW), .GUARD (GUARD), .AW (AW)
  ) uut (
    .clk (clk), .rst (rst), .inValid (inValid), .inVectoring (inVectoring),
    .inX (inX), .inY (inY), .inZ (inZ),
    .outValid (outValid), .outVectoring (outVectoring),
    .outX (outX), .outY (outY), .outZ (outZ)
  );

  always #2 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  bit monOn = 1'b0;
  int nIssued = 0;
  int rdIdx = 0;

  real   expX [NVEC];
  real   expY [NVEC];
  int    expZ [NVEC];
  bit    expVec [NVEC];
  int    issueCyc [NVEC];
  string reqTag [NVEC];
  real   gainA;

  function automatic real rabs(input real v);
    return (v < 0.0) ? -v : v;
  endfunction

  function automatic int wrapDiff(input int a, input int b);
    logic [AW-1:0] t;
    t = a[AW-1:0] - b[AW-1:0];
    return int'($signed(t));
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input real act, input real exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0f expected=%0f", req, what, act, exp);
    end
  endtask

  // Output monitor for the streamed table.
  always @(negedge clk) begin
    if (monOn && !rst && outValid) begin
      if (rdIdx >= nIssued) begin
        check(1'b0, "R1", "unexpected output", real'(rdIdx), real'(nIssued));
      end else begin
        check(outVectoring == expVec[rdIdx], "R2", "mode tag",
              real'(outVectoring), real'(expVec[rdIdx]));
        check(cyc - issueCyc[rdIdx] == STAGES + 1, "R1", "latency",
              real'(cyc - issueCyc[rdIdx]), real'(STAGES + 1));
        if (expVec[rdIdx]) begin
          check(rabs($itor(outX) - expX[rdIdx]) <= COORD_TOL, "R6", "magnitude",
                $itor(outX), expX[rdIdx]);
          check(rabs($itor(outY)) <= COORD_TOL, "R6", "y nulled",
                $itor(outY), 0.0);
          check(rabs($itor(wrapDiff(int'(outZ), expZ[rdIdx]))) <= VANG_TOL,
                reqTag[rdIdx], "vector angle", $itor(outZ), $itor(expZ[rdIdx]));
        end else begin
          check(rabs($itor(outX) - expX[rdIdx]) <= COORD_TOL, reqTag[rdIdx],
                "rotated x", $itor(outX), expX[rdIdx]);
          check(rabs($itor(outY) - expY[rdIdx]) <= COORD_TOL, reqTag[rdIdx],
                "rotated y", $itor(outY), expY[rdIdx]);
          check(rabs($itor(outZ)) <= RES_TOL, "R4", "residual angle",
                $itor(outZ), 0.0);
        end
      end
      rdIdx++;
    end
  end

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL R1 watchdog actual=timeout expected=completion");
    finishRun();
  end

  initial begin
    gainA = 1.0;
    for (int i = 0; i < STAGES; i++) gainA = gainA * $sqrt(1.0 + 2.0 ** (-2.0 * i));

    // Reset: valid input during reset is ignored (R9).
    rst = 1'b1;
    inValid = 1'b1;
    inX = 18'sd1000;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check(outValid == 1'b0, "R9", "outValid during reset", real'(outValid), 0.0);
    end
    inValid = 1'b0;
    rst = 1'b0;
    for (int i = 0; i < STAGES + 3; i++) begin
      @(negedge clk);
      check(outValid == 1'b0, "R9", "outValid after reset", real'(outValid), 0.0);
    end

    // Stream the table back to back, mixed modes (R1..R8).
    monOn = 1'b1;
    for (int e = 0; e < NVEC; e++) begin
      logic [55:0] ent;
      real xr, yr, th, zr;
      ent = TBL[e];
      @(negedge clk);
      inValid     = ent[55];
      inVectoring = ent[54];
      inX         = ent[53:36];
      inY         = ent[35:18];
      inZ         = ent[17:0];
      if (ent[55]) begin
        xr = $itor(inX);
        yr = $itor(inY);
        if (ent[54]) begin
          expX[nIssued] = gainA * $sqrt(xr * xr + yr * yr);
          expY[nIssued] = 0.0;
          zr = $itor(inZ) + $atan2(yr, xr) / (2.0 * PI) * (2.0 ** AW);
          expZ[nIssued] = $rtoi(zr + ((zr >= 0.0) ? 0.5 : -0.5));
          reqTag[nIssued] = (inX < 0) ? "R7" : "R5";
        end else begin
          th = $itor(inZ) * 2.0 * PI / (2.0 ** AW);
          expX[nIssued] = gainA * (xr * $cos(th) - yr * $sin(th));
          expY[nIssued] = gainA * (xr * $sin(th) + yr * $cos(th));
          expZ[nIssued] = 0;
          reqTag[nIssued] = (inZ > QTURN || inZ < -QTURN) ? "R8" : "R3";
        end
        expVec[nIssued]   = ent[54];
        issueCyc[nIssued] = cyc;
        nIssued++;
      end
    end
    @(negedge clk);
    inValid = 1'b0;
    repeat (STAGES + 4) @(negedge clk);
    check(rdIdx == nIssued, "R1", "output count", real'(rdIdx), real'(nIssued));
    monOn = 1'b0;

    // Reset while samples are in flight (R9).
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      inValid = 1'b1;
      inVectoring = i[0];
      inX = 18'sd40000;
      inY = 18'sd20000;
      inZ = 18'sd1000;
    end
    @(negedge clk);
    inValid = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < STAGES + 3; i++) begin
      @(negedge clk);
      check(outValid == 1'b0, "R9", "flushed pipeline", real'(outValid), 0.0);
    end

    // Quarter-turn code: vectoring (0, +y) gives 2^(AW-2) (R10).
    @(negedge clk);
    inValid = 1'b1;
    inVectoring = 1'b1;
    inX = 18'sd0;
    inY = 18'sd100000;
    inZ = 18'sd0;
    @(negedge clk);
    inValid = 1'b0;
    repeat (STAGES) @(negedge clk);
    check(outValid == 1'b1, "R10", "quarter-turn valid", real'(outValid), 1.0);
    check(rabs($itor(wrapDiff(int'(outZ), QTURN))) <= VANG_TOL, "R10",
          "quarter-turn code", $itor(outZ), $itor(QTURN));
    check(outVectoring == 1'b1, "R2", "quarter-turn mode", real'(outVectoring), 1.0);

    repeat (4) @(negedge clk);
    finishRun();
  end

endmodule